// File: doc/BRIEF.md
# Receive Queue with Sticky Interrupt Causes

This block buffers frames delivered by a serial receiver and hands them to software in arrival order. The storage is a fixed number of base words, `DEPTH`. A run-time width select groups 1, 2 or 4 base words into each entry, so the same memory holds `DEPTH`, `DEPTH/2` or `DEPTH/4` entries. The receiver side cannot be stalled. When it offers a frame and no slot is free, the frame is lost and an overflow cause is recorded.

A sticky cause register tracks these conditions:
- the entry count is above a programmable trigger level;
- the queue holds data;
- the queue is full;
- a push was dropped;
- a pop was attempted while the queue was empty.

Hardware only ever sets cause bits. Software clears them by writing ones. A mask selects which pending causes drive the single interrupt line. Deasserting `enable` empties the queue and holds every cause at zero.

Back-pressure rules:
- On the receive side, `in_ready` is advisory. A beat with `in_valid` high is stored if a slot is free after that cycle's pop. Otherwise it is dropped.
- On the read side, the entry at the head is presented with `out_valid`. It is removed on a cycle where `out_valid` and `out_ready` are both high. Raising `out_ready` while `out_valid` is low is an underflow attempt.

Top module: `rxq_top`

## Requirements
- R1: Cause bit positions are: 0 trigger, 2 not-empty, 3 full, 5 overflow, 6 underflow. Bits 1, 4 and 7 always read zero, and the register is zero after reset.
- R2: A `cause_wr` cycle clears each cause bit whose `cause_wdata` bit is 1. Bits written with 0 keep their value.
- R3: The trigger cause is set while the entry count is strictly greater than `trig_level`.
- R4: With `width_sel` 0, 1 or 2 (3 behaves as 2), the capacity is DEPTH, DEPTH/2 or DEPTH/4 entries. Each entry carries the low 8, 16 or 32 bits of `in_data`. Unused upper bits of `out_data` read zero.
- R5: A push that finds the queue full, with no pop in the same cycle, is dropped and sets overflow. A push to a full queue in the same cycle as a pop is stored, and overflow is not set.
- R6: A pop attempt on an empty queue sets underflow and leaves the queue contents and order unchanged.
- R7: The not-empty cause is set while at least one entry is held. The full cause is set while the count equals the capacity, and `in_ready` is low then.
- R8: Entries leave in the order they were accepted. `out_data` shows the head entry while `out_valid` is high.
- R9: While `enable` is low, all causes read zero, the queue is emptied (`out_valid` low), and pushes are ignored.
- R10: `irq` is high exactly when some cause bit is set whose `irq_mask` bit is also set.
- R11: When a cause condition is present in the same cycle that software writes 1 to clear it, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low empties the queue and zeroes the causes |
| width_sel | input | 2 | Entry width select; change only while disabled |
| trig_level | input | CNT_W | Trigger threshold on the entry count |
| in_valid | input | 1 | Receive frame offered |
| in_ready | output | 1 | Advisory: a slot is free |
| in_data | input | 4*DATA_W | Received frame, low-aligned |
| out_valid | output | 1 | Head entry present |
| out_ready | input | 1 | Pop request |
| out_data | output | 4*DATA_W | Head entry, upper unused bits zero |
| cause_wr | input | 1 | Write-one-to-clear strobe |
| cause_wdata | input | 8 | Bits to clear |
| cause_rdata | output | 8 | Current cause register |
| irq_mask | input | 8 | Interrupt mask, cause layout |
| irq | output | 1 | Masked interrupt request |

## Verification
The queue is filled to capacity and one past it at each of the three widths. This shows that capacity and lane packing follow `width_sel`, and that a surplus push is dropped rather than overwriting stored data. A push and a pop in the same cycle on a full queue is compared with a push alone, which separates an accepted frame from an overflow. Pops on an empty queue, followed by a push, show that underflow leaves no trace in the queue order.

Two clear patterns are applied. A clear on causes whose condition has gone makes them drop to zero. A clear on a condition still present leaves the bit set. A partial clear shows that bits written with zero are left alone. Each mask pattern is then applied to the same pending cause to show that only masked-in bits raise `irq`.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int CAUSE_W  = 8;
  localparam int C_TRIG   = 0;
  localparam int C_NEMPTY = 2;
  localparam int C_FULL   = 3;
  localparam int C_OVF    = 5;
  localparam int C_UDF    = 6;
  localparam int LANES    = 4;

  localparam logic [CAUSE_W-1:0] CAUSE_USED =
    (8'd1 << C_TRIG) | (8'd1 << C_NEMPTY) | (8'd1 << C_FULL) |
    (8'd1 << C_OVF)  | (8'd1 << C_UDF);

  // width select to log2 of base words per entry; 3 behaves as 2
  function automatic logic [1:0] width_shift(input logic [1:0] sel);
    case (sel)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] shift);
    case (shift)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [IDX_W-1:0]        wptr,
  input  logic [IDX_W-1:0]        rptr,
  input  logic [1:0]              shift,
  input  logic [LANES*DATA_W-1:0] wdata,
  output logic [LANES*DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [LANES-1:0]  lanes_on;
  logic [IDX_W-1:0]  wbase, rbase;

  assign lanes_on = lane_mask(shift);
  assign wbase    = wptr << shift;
  assign rbase    = rptr << shift;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [IDX_W-1:0] widx, ridx;
    assign widx = wbase + IDX_W'(k);
    assign ridx = rbase + IDX_W'(k);

    always_ff @(posedge clk) begin
      if (we && lanes_on[k]) mem[widx] <= wdata[k*DATA_W +: DATA_W];
    end

    assign rdata[k*DATA_W +: DATA_W] = lanes_on[k] ? mem[ridx] : '0;
  end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       shift,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             ovf_evt,
  output logic             udf_evt,
  output logic [IDX_W-1:0] wptr,
  output logic [IDX_W-1:0] rptr,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cap
);
  logic [CNT_W-1:0] cap_m1;
  logic             empty, full, w_last, r_last;

  assign cap    = CNT_W'(DEPTH) >> shift;
  assign cap_m1 = cap - 1'b1;
  assign empty  = (count == '0);
  assign full   = (count == cap);
  assign w_last = (wptr == cap_m1[IDX_W-1:0]);
  assign r_last = (rptr == cap_m1[IDX_W-1:0]);

  assign pop_ok  = enable && out_ready && !empty;
  assign push_ok = enable && in_valid && (!full || pop_ok);
  assign ovf_evt = enable && in_valid && full && !pop_ok;
  assign udf_evt = enable && out_ready && empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (!enable) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= w_last ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= r_last ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r5_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && in_valid && full && !out_ready) |=> (count == $past(count)));
  a_r6_underflow_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && out_ready && empty) |=> $stable(rptr));
  a_r7_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  a_r9_disable_empties: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (count == '0));
endmodule

// File: rtl/rxq_causes.sv
module rxq_causes
  import rxq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [CNT_W-1:0]   count,
  input  logic [CNT_W-1:0]   cap,
  input  logic [CNT_W-1:0]   trig_level,
  input  logic               ovf_evt,
  input  logic               udf_evt,
  input  logic               clr_wr,
  input  logic [CAUSE_W-1:0] clr_bits,
  output logic [CAUSE_W-1:0] cause
);
  logic [CAUSE_W-1:0] set_vec, clr_vec;

  always_comb begin
    set_vec           = '0;
    set_vec[C_TRIG]   = count > trig_level;
    set_vec[C_NEMPTY] = count != '0;
    set_vec[C_FULL]   = count == cap;
    set_vec[C_OVF]    = ovf_evt;
    set_vec[C_UDF]    = udf_evt;
    clr_vec           = clr_wr ? clr_bits : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cause <= '0;
    else if (!enable) cause <= '0;
    else              cause <= ((cause & ~clr_vec) | set_vec) & CAUSE_USED;
  end

  a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cause & ~CAUSE_USED) == '0);
  a_r2_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && clr_wr) |=> ((cause & $past(clr_bits & ~set_vec)) == '0));
  a_r3_trigger_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && count > trig_level) |=> cause[C_TRIG]);
  a_r9_off_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cause == '0));
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && clr_wr && clr_bits[C_OVF] && ovf_evt) |=> cause[C_OVF]);
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int CNT_W  = IDX_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic [1:0]              width_sel,
  input  logic [CNT_W-1:0]        trig_level,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*DATA_W-1:0] in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*DATA_W-1:0] out_data,
  input  logic                    cause_wr,
  input  logic [CAUSE_W-1:0]      cause_wdata,
  output logic [CAUSE_W-1:0]      cause_rdata,
  input  logic [CAUSE_W-1:0]      irq_mask,
  output logic                    irq
);
  logic [1:0]       shift;
  logic             push_ok, pop_ok, ovf_evt, udf_evt;
  logic [IDX_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] count, cap;
  logic [CAUSE_W-1:0] cause;

  assign shift = width_shift(width_sel);

  rxq_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .shift(shift),
    .in_valid(in_valid), .out_ready(out_ready),
    .push_ok(push_ok), .pop_ok(pop_ok), .ovf_evt(ovf_evt), .udf_evt(udf_evt),
    .wptr(wptr), .rptr(rptr), .count(count), .cap(cap)
  );

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk(clk), .we(push_ok), .wptr(wptr), .rptr(rptr), .shift(shift),
    .wdata(in_data), .rdata(out_data)
  );

  rxq_causes #(.CNT_W(CNT_W)) u_causes (
    .clk(clk), .rst_n(rst_n), .enable(enable), .count(count), .cap(cap),
    .trig_level(trig_level), .ovf_evt(ovf_evt), .udf_evt(udf_evt),
    .clr_wr(cause_wr), .clr_bits(cause_wdata), .cause(cause)
  );

  assign cause_rdata = cause;
  assign irq         = |(cause & irq_mask);
  assign out_valid   = enable && (count != '0);
  assign in_ready    = enable && (count != cap);

  a_r7_not_empty_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && out_valid && $past(out_valid)) |-> cause[C_NEMPTY]);
  a_r9_no_output_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !out_valid);
endmodule

// File: tb/test_rxq_top.sv
module test_rxq_top;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;
  localparam int CNT_W  = 5;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        enable = 0;
  logic [1:0]  width_sel = 0;
  logic [CNT_W-1:0] trig_level = 5'd16;
  logic        in_valid = 0;
  logic        in_ready;
  logic [31:0] in_data = 0;
  logic        out_valid;
  logic        out_ready = 0;
  logic [31:0] out_data;
  logic        cause_wr = 0;
  logic [7:0]  cause_wdata = 0;
  logic [7:0]  cause_rdata;
  logic [7:0]  irq_mask = 0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  rxq_top #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_rxq_top (
    .clk(clk), .rst_n(rst_n), .enable(enable), .width_sel(width_sel),
    .trig_level(trig_level), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .cause_wr(cause_wr), .cause_wdata(cause_wdata),
    .cause_rdata(cause_rdata), .irq_mask(irq_mask), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic push(input logic [31:0] d);
    in_valid = 1; in_data = d;
    tick();
    in_valid = 0;
  endtask

  task automatic pop_expect(input string req, input logic [31:0] d);
    check(req, {31'd0, out_valid}, 32'd1);
    check(req, out_data, d);
    out_ready = 1;
    tick();
    out_ready = 0;
  endtask

  task automatic clear(input logic [7:0] bits);
    cause_wr = 1; cause_wdata = bits;
    tick();
    cause_wr = 0; cause_wdata = 0;
  endtask

  task automatic reconfig(input logic [1:0] sel);
    enable = 0; tick();
    width_sel = sel; tick();
    enable = 1; tick();
  endtask

  task automatic t_reset;
    check("R1 reset cause", {24'd0, cause_rdata}, 32'd0);
    check("R9 reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R10 reset irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_fill_overflow;
    for (int i = 0; i < 16; i++) push(32'h10 + i);
    tick();
    check("R7 full+not_empty", {24'd0, cause_rdata}, 32'h0C);
    check("R7 in_ready low when full", {31'd0, in_ready}, 32'd0);
    push(32'hEE);
    tick();
    check("R5 overflow set", {24'd0, cause_rdata}, 32'h2C);
    for (int i = 0; i < 16; i++) pop_expect("R8 order width0", 32'h10 + i);
    check("R8 empty after drain", {31'd0, out_valid}, 32'd0);
    tick();
    check("R1 sticky causes", {24'd0, cause_rdata}, 32'h2C);
    clear(8'h20);
    check("R2 zero bits kept", {24'd0, cause_rdata}, 32'h0C);
    clear(8'h0C);
    check("R2 cleared", {24'd0, cause_rdata}, 32'h00);
  endtask

  task automatic t_underflow;
    out_ready = 1; tick(); out_ready = 0;
    check("R6 underflow set", {24'd0, cause_rdata}, 32'h40);
    push(32'h55);
    push(32'h56);
    pop_expect("R6 order intact", 32'h55);
    pop_expect("R6 order intact", 32'h56);
    tick();
    clear(8'hFF);
    check("R6 clear", {24'd0, cause_rdata}, 32'h00);
  endtask

  task automatic t_trigger;
    trig_level = 5'd2;
    push(32'h1); push(32'h2); tick();
    check("R3 count==level no trigger", {31'd0, cause_rdata[0]}, 32'd0);
    push(32'h3); tick();
    check("R3 count>level trigger", {31'd0, cause_rdata[0]}, 32'd1);
    for (int i = 1; i <= 3; i++) pop_expect("R3 drain", i);
    trig_level = 5'd16;
    tick();
    clear(8'hFF);
    check("R3 clear", {24'd0, cause_rdata}, 32'h00);
  endtask

  task automatic t_set_wins;
    push(32'h77); tick();
    clear(8'h04);
    check("R11 set wins over clear", {24'd0, cause_rdata}, 32'h04);
    pop_expect("R11 drain", 32'h77);
    tick();
    clear(8'hFF);
    check("R11 clear after drain", {24'd0, cause_rdata}, 32'h00);
  endtask

  task automatic t_push_pop_full;
    for (int i = 0; i < 16; i++) push(32'h40 + i);
    in_valid = 1; in_data = 32'h99; out_ready = 1;
    tick();
    in_valid = 0; out_ready = 0;
    tick();
    check("R5 push+pop on full no overflow", {24'd0, cause_rdata}, 32'h0C);
    for (int i = 1; i < 16; i++) pop_expect("R5 order after push+pop", 32'h40 + i);
    pop_expect("R5 accepted frame", 32'h99);
    tick();
    clear(8'hFF);
    check("R5 clear", {24'd0, cause_rdata}, 32'h00);
  endtask

  task automatic t_width(input logic [1:0] sel, input int cap, input logic [31:0] keep);
    reconfig(sel);
    for (int i = 0; i < cap; i++) push(32'hA5C30000 + 32'h1111 * i + i);
    tick();
    check("R4 full at capacity", {24'd0, cause_rdata}, 32'h0C);
    check("R4 in_ready low", {31'd0, in_ready}, 32'd0);
    push(32'hFFFFFFFF);
    tick();
    check("R4 overflow past capacity", {24'd0, cause_rdata}, 32'h2C);
    for (int i = 0; i < cap; i++)
      pop_expect("R4 lane packing", (32'hA5C30000 + 32'h1111 * i + i) & keep);
    check("R4 drained", {31'd0, out_valid}, 32'd0);
    tick();
    clear(8'hFF);
  endtask

  task automatic t_disable;
    reconfig(2'd0);
    push(32'h1); push(32'h2); push(32'h3);
    tick();
    check("R9 precondition", {24'd0, cause_rdata}, 32'h04);
    enable = 0; tick();
    check("R9 causes zero", {24'd0, cause_rdata}, 32'h00);
    check("R9 emptied", {31'd0, out_valid}, 32'd0);
    push(32'h9); tick();
    check("R9 push ignored", {31'd0, out_valid}, 32'd0);
    enable = 1; tick();
    check("R9 empty after re-enable", {31'd0, out_valid}, 32'd0);
    check("R9 causes zero after re-enable", {24'd0, cause_rdata}, 32'h00);
  endtask

  task automatic t_irq;
    out_ready = 1; tick(); out_ready = 0;
    irq_mask = 8'h40; #1;
    check("R10 masked-in irq", {31'd0, irq}, 32'd1);
    irq_mask = 8'hBF; #1;
    check("R10 masked-out irq", {31'd0, irq}, 32'd0);
    clear(8'hFF);
    irq_mask = 8'hFF; #1;
    check("R10 no cause no irq", {31'd0, irq}, 32'd0);
    irq_mask = 8'h00;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    tick(2);
    t_reset();
    rst_n = 1;
    tick();
    enable = 1;
    tick();
    t_reset();
    t_fill_overflow();
    t_underflow();
    t_trigger();
    t_set_wins();
    t_push_pop_full();
    t_width(2'd1, 8, 32'h0000FFFF);
    t_width(2'd2, 4, 32'hFFFFFFFF);
    t_width(2'd3, 4, 32'hFFFFFFFF);
    t_width(2'd0, 16, 32'h000000FF);
    t_disable();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule